// File: doc/BRIEF.md
# Triple Frame Buffer Write/Read Synchronizer

This block coordinates a writer and a display reader that share a ring of frame buffers in external memory. Three buffers is the default. On the capture side it watches a vertical sync input and a pixel-valid flag. It throws away every blanking sample. For each valid pixel it issues one write request, carrying a word address inside the buffer currently being filled. Each rising edge of vertical sync closes the frame in progress and moves the writer to the next buffer of the ring.

On the display side, the reader pulses a frame-start input at the top of each displayed frame. At that moment the block latches the buffer to fetch, which is always the one the writer finished most recently. The reader therefore runs exactly one frame behind and is never pointed at the buffer being filled. Each buffer starts at a programmable base address plus its index times a programmable stride. Until a whole frame has been captured, the block tells the reader to show black. The default frame is 742 by 480 active pixels.

Top module: `fb_tri_sync`

## Requirements
- R1: While reset is held and right after it, wr_req is 0, wr_buf is NBUF-1 (2 by default), rd_idx is 0, rd_base is 0 and rd_black is 1.
- R2: A write request (wr_req high for one cycle, with wr_data equal to cap_pixel) appears one cycle after each cycle in which cap_active is high, provided a rising edge of cap_vsync has been seen at or before that cycle. Pixels before the first rising edge and all cycles with cap_active low produce no request.
- R3: A rising edge of cap_vsync means 0 in the previous cycle and 1 in this one. Each rising edge advances wr_buf around the ring 0, 1, …, NBUF-1, 0 at the next clock edge. A vsync held high does not advance it again.
- R4: The address of a request is cfg_base + b*cfg_stride + n, truncated to AW bits. Here b is the write buffer for that pixel and n is the number of pixels already accepted in the same frame. A pixel that arrives in the same cycle as a vsync rising edge belongs to the new buffer with n = 0.
- R5: Within one frame, at most H_ACT*V_ACT pixels are written. Further active pixels in that frame produce no request.
- R6: One cycle after disp_fstart is high, rd_idx equals the buffer before w in the ring ((w+NBUF-1) mod NBUF), where w is the write buffer as updated by that same clock edge. At that point rd_base equals cfg_base + rd_idx*cfg_stride. Both hold their values until the next disp_fstart.
- R7: rd_black stays 1 until a disp_fstart occurs at which at least one frame is complete, meaning a second vsync rising edge has been seen at or before that cycle. After that it is 0 until reset.
- R8: When a vsync rising edge and disp_fstart fall in the same cycle, the reader is given the buffer the writer just closed, and the writer moves on to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Address of buffer 0 |
| cfg_stride | input | AW | Distance in words between consecutive buffers |
| cap_vsync | input | 1 | Capture vertical sync; a rising edge starts a frame |
| cap_active | input | 1 | Capture pixel valid (low during blanking) |
| cap_pixel | input | PW | Capture pixel word |
| disp_fstart | input | 1 | Display frame-start pulse from the reader |
| wr_req | output | 1 | Write request to memory, one word |
| wr_addr | output | AW | Write word address |
| wr_data | output | PW | Write data |
| wr_buf | output | IW | Buffer index the writer is filling |
| rd_idx | output | IW | Buffer index the reader must fetch |
| rd_base | output | AW | Base address of the buffer to fetch |
| rd_black | output | 1 | Reader must output black (no complete frame yet) |

## Verification
The delicate case is a cycle where the writer's frame start (a vsync rising edge) and the reader's frame start land together. The read index must then come from the write index after the advance, not before it. Otherwise the reader would be two frames behind. The bench forces this collision directly and also lets it occur by chance in random traffic. It judges the result against an independent model: the reader must be given the buffer just closed, and the writer must move to its successor. A second coincidence, a valid pixel in the vsync rising-edge cycle, is driven on purpose. Its address must be offset zero of the new buffer.

// File: rtl/fb_sync_pkg.sv
package fb_sync_pkg;

  function automatic int unsigned ring_next(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  function automatic int unsigned ring_prev(input int unsigned i, input int unsigned n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  function automatic logic [63:0] buf_base(input logic [63:0] base,
                                           input logic [63:0] stride,
                                           input int unsigned idx);
    return base + stride * 64'(idx);
  endfunction

endpackage

// File: rtl/fb_rise_det.sv
module fb_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/fb_wr_side.sv
module fb_wr_side #(
  parameter int unsigned NBUF = 3,
  parameter int unsigned IW   = 2,
  parameter int unsigned AW   = 32,
  parameter int unsigned PW   = 24,
  parameter int unsigned FW   = 16,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs,
  input  logic          cap_active,
  input  logic [PW-1:0] cap_pixel,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_data,
  output logic [IW-1:0] idx_q,
  output logic [IW-1:0] idx_nx,
  output logic          done_nx
);
  logic [CW-1:0] cnt_q, cnt_e;
  logic          started_q, live, done_q, accept;

  always_comb begin
    idx_nx  = fs ? IW'(fb_sync_pkg::ring_next(32'(idx_q), NBUF)) : idx_q;
    cnt_e   = fs ? '0 : cnt_q;
    live    = started_q | fs;
    done_nx = done_q | (fs & started_q);
    accept  = cap_active & live & (cnt_e < CW'(FW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= IW'(NBUF - 1);
      cnt_q     <= '0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      idx_q     <= idx_nx;
      started_q <= live;
      done_q    <= done_nx;
      cnt_q     <= accept ? cnt_e + 1'b1 : cnt_e;
      wr_req    <= accept;
      if (accept) begin
        wr_addr <= AW'(fb_sync_pkg::buf_base(64'(cfg_base), 64'(cfg_stride), 32'(idx_nx)))
                   + AW'(cnt_e);
        wr_data <= cap_pixel;
      end
    end
  end
endmodule

// File: rtl/fb_rd_side.sv
module fb_rd_side #(
  parameter int unsigned NBUF = 3,
  parameter int unsigned IW   = 2,
  parameter int unsigned AW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_fstart,
  input  logic [IW-1:0] wr_idx_nx,
  input  logic          wr_done_nx,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  output logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_base,
  output logic          rd_black
);
  logic [IW-1:0] lag_idx;

  assign lag_idx = IW'(fb_sync_pkg::ring_prev(32'(wr_idx_nx), NBUF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx   <= '0;
      rd_base  <= '0;
      rd_black <= 1'b1;
    end else if (disp_fstart) begin
      rd_idx   <= lag_idx;
      rd_base  <= AW'(fb_sync_pkg::buf_base(64'(cfg_base), 64'(cfg_stride), 32'(lag_idx)));
      rd_black <= ~wr_done_nx;
    end
  end
endmodule

// File: rtl/fb_tri_sync.sv
module fb_tri_sync #(
  parameter int unsigned NBUF  = 3,
  parameter int unsigned H_ACT = 742,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned AW    = 32,
  parameter int unsigned PW    = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           cfg_base,
  input  logic [AW-1:0]           cfg_stride,
  input  logic                    cap_vsync,
  input  logic                    cap_active,
  input  logic [PW-1:0]           cap_pixel,
  input  logic                    disp_fstart,
  output logic                    wr_req,
  output logic [AW-1:0]           wr_addr,
  output logic [PW-1:0]           wr_data,
  output logic [$clog2(NBUF)-1:0] wr_buf,
  output logic [$clog2(NBUF)-1:0] rd_idx,
  output logic [AW-1:0]           rd_base,
  output logic                    rd_black
);
  localparam int unsigned IW = $clog2(NBUF);
  localparam int unsigned FW = H_ACT * V_ACT;
  localparam int unsigned CW = $clog2(FW + 1);

  // Internal events brought out by name for the checker
  logic          wr_fs_evt;
  logic [IW-1:0] wr_idx_nx;
  logic          wr_done_nx;

  fb_rise_det u_vs (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (cap_vsync),
    .rise (wr_fs_evt)
  );

  fb_wr_side #(.NBUF(NBUF), .IW(IW), .AW(AW), .PW(PW), .FW(FW), .CW(CW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (wr_fs_evt),
    .cap_active(cap_active),
    .cap_pixel (cap_pixel),
    .cfg_base  (cfg_base),
    .cfg_stride(cfg_stride),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .idx_q     (wr_buf),
    .idx_nx    (wr_idx_nx),
    .done_nx   (wr_done_nx)
  );

  fb_rd_side #(.NBUF(NBUF), .IW(IW), .AW(AW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_fstart(disp_fstart),
    .wr_idx_nx  (wr_idx_nx),
    .wr_done_nx (wr_done_nx),
    .cfg_base   (cfg_base),
    .cfg_stride (cfg_stride),
    .rd_idx     (rd_idx),
    .rd_base    (rd_base),
    .rd_black   (rd_black)
  );
endmodule

// File: rtl/fb_tri_sync_chk.sv
module fb_tri_sync_chk #(
  parameter int unsigned NBUF = 3,
  parameter int unsigned IW   = 2,
  parameter int unsigned AW   = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_fs_evt,
  input logic          disp_fstart,
  input logic          cap_active,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] cfg_base,
  input logic [AW-1:0] cfg_stride,
  input logic [IW-1:0] wr_buf,
  input logic [IW-1:0] rd_idx,
  input logic          rd_black
);
  // R2: a request always follows an active pixel
  a_r2_req_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(cap_active));

  // R3: ring advance on each frame start
  a_r3_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fs_evt |=> wr_buf == (($past(wr_buf) == IW'(NBUF - 1)) ? '0 : $past(wr_buf) + 1'b1));

  // R4: back-to-back requests in one frame use consecutive words
  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && $past(wr_req) && !$past(wr_fs_evt) &&
     $past(cfg_base) == $past(cfg_base, 2) && $past(cfg_stride) == $past(cfg_stride, 2))
    |-> wr_addr == $past(wr_addr) + 1'b1);

  // R6: reader never handed the buffer being written
  a_r6_not_writer: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fstart |=> rd_idx != wr_buf);

  // R7: black is released only at a display frame start
  a_r7_black_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_black) |-> $past(disp_fstart));

  // R7: black never returns once released
  a_r7_black_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_black |=> !rd_black);
endmodule

bind fb_tri_sync fb_tri_sync_chk #(.NBUF(NBUF), .IW(IW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_fs_evt  (wr_fs_evt),
  .disp_fstart(disp_fstart),
  .cap_active (cap_active),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .cfg_base   (cfg_base),
  .cfg_stride (cfg_stride),
  .wr_buf     (wr_buf),
  .rd_idx     (rd_idx),
  .rd_black   (rd_black)
);

// File: tb/sim_fb_tri_sync.sv
module sim_fb_tri_sync;
  localparam int NB = 3;
  localparam int HA = 6;
  localparam int VA = 3;
  localparam int FWD = HA * VA;
  localparam int AWD = 20;
  localparam int PWD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AWD-1:0] cfg_base = '0, cfg_stride = '0;
  logic cap_vsync = 1'b0, cap_active = 1'b0, disp_fstart = 1'b0;
  logic [PWD-1:0] cap_pixel = '0;
  logic wr_req, rd_black;
  logic [AWD-1:0] wr_addr, rd_base;
  logic [PWD-1:0] wr_data;
  logic [1:0] wr_buf, rd_idx;

  always #2 clk = ~clk;

  fb_tri_sync #(.NBUF(NB), .H_ACT(HA), .V_ACT(VA), .AW(AWD), .PW(PWD)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cap_vsync(cap_vsync), .cap_active(cap_active), .cap_pixel(cap_pixel),
    .disp_fstart(disp_fstart), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_buf(wr_buf), .rd_idx(rd_idx), .rd_base(rd_base), .rd_black(rd_black)
  );

  int checks = 0, failures = 0, frame_reqs = 0;
  // model state
  int m_idx, m_cnt, m_vs, m_st, m_hf;
  int e_req, e_rd_idx, e_black;
  longint e_addr, e_data, e_rd_base;

  function automatic int nxt(int i); return (i + 1) % NB; endfunction
  function automatic int lag(int i); return (i + NB - 1) % NB; endfunction
  function automatic longint addr_of(longint b, longint s, int i, int n);
    return (b + s * i + n) & ((64'd1 << AWD) - 1);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit vs, input bit act, input bit dfs);
    int fs, acc;
    cap_vsync = vs; cap_active = act; disp_fstart = dfs;
    cap_pixel = PWD'($urandom);
    @(posedge clk);
    fs = (vs && !m_vs) ? 1 : 0;
    m_vs = vs;
    if (fs != 0) begin
      if (m_st != 0) m_hf = 1;
      m_idx = nxt(m_idx); m_cnt = 0; m_st = 1;
    end
    acc = (act && m_st != 0 && m_cnt < FWD) ? 1 : 0;
    e_req = acc;
    if (acc != 0) begin
      e_addr = addr_of(longint'(cfg_base), longint'(cfg_stride), m_idx, m_cnt);
      e_data = longint'(cap_pixel);
      m_cnt++;
    end
    if (dfs) begin
      e_rd_idx = lag(m_idx);
      e_rd_base = addr_of(longint'(cfg_base), longint'(cfg_stride), e_rd_idx, 0);
      e_black = (m_hf != 0) ? 0 : 1;
    end
    #1;
    chk("R3 wr_buf", longint'(wr_buf), m_idx);
    chk("R2 wr_req", longint'(wr_req), e_req);
    if (e_req != 0) begin
      chk("R4 wr_addr", longint'(wr_addr), e_addr);
      chk("R2 wr_data", longint'(wr_data), e_data);
    end
    chk("R6 rd_idx", longint'(rd_idx), e_rd_idx);
    chk("R6 rd_base", longint'(rd_base), e_rd_base);
    chk("R7 rd_black", longint'(rd_black), e_black);
    if (wr_req) frame_reqs++;
  endtask

  task automatic frame(input int npix, input bit dfs_first);
    int sent = 0;
    frame_reqs = 0;
    cycle(1'b1, 1'b0, dfs_first);
    cycle(1'b1, 1'b0, 1'b0);
    while (sent < npix) begin
      bit a = ($urandom % 4) != 0;
      cycle(1'b0, a, ($urandom % 37) == 0);
      if (a) sent++;
    end
    repeat (3) cycle(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int old;
    void'($urandom(32'd4242));
    cfg_base = 20'h100; cfg_stride = 20'h40;
    m_idx = NB - 1; m_cnt = 0; m_vs = 0; m_st = 0; m_hf = 0;
    e_req = 0; e_rd_idx = 0; e_black = 1; e_addr = 0; e_data = 0; e_rd_base = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 wr_req", longint'(wr_req), 0);
    chk("R1 wr_buf", longint'(wr_buf), NB - 1);
    chk("R1 rd_idx", longint'(rd_idx), 0);
    chk("R1 rd_base", longint'(rd_base), 0);
    chk("R1 rd_black", longint'(rd_black), 1);
    rst_n = 1'b1;

    // R2: pixels before first vsync are dropped
    frame_reqs = 0;
    repeat (5) cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b0, 1'b0, 1'b1);
    chk("R2 no writes before first vsync", frame_reqs, 0);

    // R4: pixel in the rise cycle lands at offset 0 of the new buffer
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R4 rise-cycle pixel addr", longint'(wr_addr),
        addr_of(longint'(cfg_base), longint'(cfg_stride), 0, 0));
    // R7: first frame still incomplete -> black after a display start
    chk("R7 black during first frame", longint'(rd_black), 1);
    repeat (10) cycle(1'b0, 1'b1, 1'b0);
    repeat (2) cycle(1'b0, 1'b0, 1'b0);

    // R5: 25 pixels offered, only a frame's worth written
    frame(25, 1'b0);
    chk("R5 writes capped per frame", frame_reqs, FWD);
    cycle(1'b0, 1'b0, 1'b1);
    chk("R7 black cleared after complete frame", longint'(rd_black), 0);
    chk("R6 reader lags writer", longint'(rd_idx), lag(int'(wr_buf)));

    // R8: collision of both frame starts
    old = int'(wr_buf);
    cycle(1'b1, 1'b0, 1'b1);
    chk("R8 reader gets closed buffer", longint'(rd_idx), old);
    chk("R8 writer moves on", longint'(wr_buf), nxt(old));
    repeat (3) cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);

    // random frames, config changes between frames
    for (int f = 0; f < 24; f++) begin
      if ((f % 5) == 4) begin
        cfg_base = AWD'($urandom % 4096);
        cfg_stride = AWD'(FWD + ($urandom % 46));
      end
      frame(int'($urandom % 23), ($urandom % 3) == 0);
      cycle(1'b0, 1'b0, 1'b1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule